// File: doc/BRIEF.md
# Interrupt Status Collector with Compare Timer

This block gathers single-cycle event pulses into sticky status flags and raises one interrupt line for any flag that software has unmasked. Next to the flags it runs a free-running up-counter and a compare register. When the compare register holds a nonzero value and the counter equals it, a timeout flag is raised. A compare value of zero shuts the timeout source off.

Software reaches four registers through a small read/write port with a two-bit address. Address 0 is the status register. Reading it returns the flags and clears all of them in the same cycle. Writing it does nothing. Address 1 is the mask, address 2 is the counter (any write zeroes it) and address 3 is the compare value. Read data is registered. It appears in the cycle after the read strobe and holds its value until the next read.

A two-state compare controller tracks whether the timeout source is live. It is in CMP_OFF after reset and whenever the compare register holds zero. The transition CMP_OFF to CMP_ARMED happens on a write of a nonzero compare value. The transition CMP_ARMED to CMP_OFF happens on a write of zero. In every other case the controller stays in its state.

Top module: `irq_status_timer`

## Requirements
- R1: After reset, irq and reg_rdata are 0. Status, mask, counter and compare are all 0, so reads of addresses 0, 1 and 3 return 0.
- R2: A high on ev_pulse[k] sets status bit k (bits 0 to NUM_EV-1). The bit stays set until a status read clears it.
- R3: A high on sys_err sets status bit NUM_EV (bit 6 by default), which is sticky in the same way.
- R4: irq is registered. In each cycle it equals the OR over all bits of (status AND mask) as they stood in the previous cycle. A set bit whose mask bit is 0 never drives irq.
- R5: A read of address 0 returns the status bits in the low bits of reg_rdata, with the upper bits 0. The same edge clears every status bit.
- R6: A write to address 0 leaves the status register unchanged.
- R7: An event, sys_err or timeout that arrives in the same cycle as a status read is set after that read and is not lost.
- R8: The counter increments by one every clock. A write of any value to address 2 loads 0 in place of the increment. A read of address 2 returns the counter value in the cycle of the read strobe.
- R9: While the compare register is nonzero, status bit NUM_EV+1 (bit 7 by default) is set one cycle after each cycle in which the counter equals the compare value.
- R10: While the compare register holds 0, status bit NUM_EV+1 is never set.
- R11: Reads of addresses 1 and 3 return the current mask (zero-extended) and compare values. reg_rdata is updated only by a read and holds between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_pulse | input | NUM_EV | Single-cycle event pulses, one per status bit |
| sys_err | input | 1 | System-error event pulse |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 counter, 3 compare |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Single event pulses are followed by status reads. This separates stickiness from clear-on-read and shows that bits outside the pulse stay clear. Masked and unmasked flags are compared on irq, which isolates the mask gating and the one-cycle registration. Events that coincide with a status read, and writes to the status address, separate a correct set-over-clear priority from a lost event or a writable register. Compare runs with small nonzero values after counter clears, repeated, plus long runs with a zero compare, distinguish a true equality match from an off-by-one and from a timeout that fires while disabled. A long pseudo-random mix of all strobes and pulses is checked cycle by cycle against a behavioural model.

// File: rtl/irq_tmr_pkg.sv
package irq_tmr_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK   = 2'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CMP    = 2'd3;

    typedef enum logic {
        CMP_OFF   = 1'b0,
        CMP_ARMED = 1'b1
    } cmp_state_e;

endpackage

// File: rtl/irq_tmr_counter.sv
module irq_tmr_counter
    import irq_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp,
    output logic             hit
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cmp_state_e       state_q, state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;

    // free-running counter, cleared by a write to its address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_wr) begin
            cmp_q <= cmp_wdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CMP_OFF;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CMP_OFF: begin
                if (cmp_wr && (cmp_wdata != '0)) begin
                    state_nx = CMP_ARMED;
                end
            end
            CMP_ARMED: begin
                if (cmp_wr && (cmp_wdata == '0)) begin
                    state_nx = CMP_OFF;
                end
            end
            default: state_nx = CMP_OFF;
        endcase
    end

    // outputs
    always_comb begin
        hit = 1'b0;
        unique case (state_q)
            CMP_OFF:   hit = 1'b0;
            CMP_ARMED: hit = (cnt_q == cmp_q);
            default:   hit = 1'b0;
        endcase
    end

    assign cnt = cnt_q;
    assign cmp = cmp_q;

endmodule

// File: rtl/irq_tmr_status.sv
module irq_tmr_status #(
    parameter int ST_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set_vec,
    input  logic            rd_clr,
    input  logic            mask_wr,
    input  logic [ST_W-1:0] mask_wdata,
    output logic [ST_W-1:0] st,
    output logic [ST_W-1:0] mask,
    output logic            irq
);

    logic [ST_W-1:0] st_q;
    logic [ST_W-1:0] mask_q;
    logic            irq_q;

    // one sticky flag per source; a set in the clearing cycle wins
    for (genvar i = 0; i < ST_W; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[i] <= 1'b0;
            end else begin
                st_q[i] <= (st_q[i] & ~rd_clr) | set_vec[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(st_q & mask_q);
        end
    end

    assign st   = st_q;
    assign mask = mask_q;
    assign irq  = irq_q;

endmodule

// File: rtl/irq_tmr_rdport.sv
module irq_tmr_rdport
    import irq_tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ST_W   = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ST_W-1:0]   st,
    input  logic [ST_W-1:0]   mask,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  cmp,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] sel;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        sel = '0;
        unique case (addr)
            A_STATUS: sel[ST_W-1:0]  = st;
            A_MASK:   sel[ST_W-1:0]  = mask;
            A_COUNT:  sel[CNT_W-1:0] = cnt;
            A_CMP:    sel[CNT_W-1:0] = cmp;
            default:  sel = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd) begin
            rdata_q <= sel;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/irq_status_timer.sv
module irq_status_timer
    import irq_tmr_pkg::*;
#(
    parameter int NUM_EV = 6,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_pulse,
    input  logic              sys_err,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int ST_W    = NUM_EV + 2;
    localparam int ERR_BIT = NUM_EV;
    localparam int TMO_BIT = NUM_EV + 1;

    logic [ST_W-1:0]  st_w;
    logic [ST_W-1:0]  mask_w;
    logic [ST_W-1:0]  set_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] cmp_w;
    logic             hit_w;
    logic             rd_status;
    logic             wr_mask;
    logic             wr_count;
    logic             wr_cmp;

    assign rd_status = reg_rd && (reg_addr == A_STATUS);
    assign wr_mask   = reg_wr && (reg_addr == A_MASK);
    assign wr_count  = reg_wr && (reg_addr == A_COUNT);
    assign wr_cmp    = reg_wr && (reg_addr == A_CMP);

    always_comb begin
        set_w                = '0;
        set_w[NUM_EV-1:0]    = ev_pulse;
        set_w[ERR_BIT]       = sys_err;
        set_w[TMO_BIT]       = hit_w;
    end

    irq_tmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_clr   (wr_count),
        .cmp_wr    (wr_cmp),
        .cmp_wdata (reg_wdata[CNT_W-1:0]),
        .cnt       (cnt_w),
        .cmp       (cmp_w),
        .hit       (hit_w)
    );

    irq_tmr_status #(.ST_W(ST_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_w),
        .rd_clr     (rd_status),
        .mask_wr    (wr_mask),
        .mask_wdata (reg_wdata[ST_W-1:0]),
        .st         (st_w),
        .mask       (mask_w),
        .irq        (irq)
    );

    irq_tmr_rdport #(.DATA_W(DATA_W), .ST_W(ST_W), .CNT_W(CNT_W)) u_rdport (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (reg_rd),
        .addr  (reg_addr),
        .st    (st_w),
        .mask  (mask_w),
        .cnt   (cnt_w),
        .cmp   (cmp_w),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/irq_status_timer_chk.sv
module irq_status_timer_chk
    import irq_tmr_pkg::*;
#(
    parameter int NUM_EV = 6,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_EV-1:0] ev_pulse,
    input logic              sys_err,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic              irq,
    input logic [NUM_EV+1:0] st,
    input logic [NUM_EV+1:0] mask,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp
);

    logic rd_st;
    assign rd_st = reg_rd && (reg_addr == A_STATUS);

    assert_event_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_pulse) |=> ((st[NUM_EV-1:0] & $past(ev_pulse)) == $past(ev_pulse)));

    assert_irq_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(st & mask))));

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st && (ev_pulse == '0) && !sys_err) |=> (st[NUM_EV:0] == '0));

    assert_event_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st && (|ev_pulse)) |=> ((st[NUM_EV-1:0] & $past(ev_pulse)) == $past(ev_pulse)));

    assert_counter_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == A_COUNT)) |=> (cnt == $past(cnt) + CNT_W'(1)));

    assert_no_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp == '0) && !st[NUM_EV+1]) |=> !st[NUM_EV+1]);

endmodule

bind irq_status_timer irq_status_timer_chk #(.NUM_EV(NUM_EV), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_pulse (ev_pulse),
    .sys_err  (sys_err),
    .reg_addr (reg_addr),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .irq      (irq),
    .st       (st_w),
    .mask     (mask_w),
    .cnt      (cnt_w),
    .cmp      (cmp_w)
);

// File: tb/irq_status_timer_test.sv
`timescale 1ns/1ps
module irq_status_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ev_pulse = '0;
    logic        sys_err = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_cmp  = 0;
    int n_fail = 0;

    // behavioural reference state
    logic [7:0]  m_st = '0, m_mask = '0;
    logic [31:0] m_cnt = '0, m_cmp = '0, m_rdata = '0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_timer uut (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .sys_err(sys_err),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input logic [5:0] ev, input logic se,
                        input logic rd, input logic wr, input logic [1:0] a,
                        input logic [31:0] wd);
        logic        hit;
        logic [31:0] n_rd, n_cnt, n_cmpv;
        logic [7:0]  n_st, n_mask;
        logic        n_irq;
        @(negedge clk);
        ev_pulse = ev; sys_err = se; reg_rd = rd; reg_wr = wr;
        reg_addr = a; reg_wdata = wd;
        hit  = (m_cmp != 0) && (m_cnt == m_cmp);
        n_rd = m_rdata;
        if (rd) begin
            case (a)
                2'd0: n_rd = {24'h0, m_st};
                2'd1: n_rd = {24'h0, m_mask};
                2'd2: n_rd = m_cnt;
                default: n_rd = m_cmp;
            endcase
        end
        n_irq  = |(m_st & m_mask);
        n_st   = ((rd && a == 2'd0) ? 8'h00 : m_st) | {hit, se, ev};
        n_mask = (wr && a == 2'd1) ? wd[7:0] : m_mask;
        n_cmpv = (wr && a == 2'd3) ? wd : m_cmp;
        n_cnt  = (wr && a == 2'd2) ? 32'h0 : m_cnt + 32'd1;
        @(posedge clk);
        m_rdata = n_rd; m_irq = n_irq; m_st = n_st; m_mask = n_mask;
        m_cmp = n_cmpv; m_cnt = n_cnt;
        #1;
        check(tag, "irq", {31'h0, irq}, {31'h0, m_irq});
        check(tag, "rdata", reg_rdata, m_rdata);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 6'h0, 1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic rd_reg(input string tag, input logic [1:0] a);
        step(tag, 6'h0, 1'b0, 1'b1, 1'b0, a, 32'h0);
    endtask

    task automatic wr_reg(input string tag, input logic [1:0] a, input logic [31:0] d);
        step(tag, 6'h0, 1'b0, 1'b0, 1'b1, a, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "irq in reset", {31'h0, irq}, 32'h0);
        check("R1", "rdata in reset", reg_rdata, 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;
        // R1: registers read zero after reset
        rd_reg("R1", 2'd0); rd_reg("R1", 2'd1); rd_reg("R1", 2'd3); rd_reg("R1", 2'd2);
        // R2: event bits stick until read
        step("R2", 6'b000101, 1'b0, 1'b0, 1'b0, 2'd0, 0);
        idle("R2", 3);
        rd_reg("R2", 2'd0); rd_reg("R2", 2'd0);
        // R3: system error bit
        step("R3", 6'h0, 1'b1, 1'b0, 1'b0, 2'd0, 0);
        rd_reg("R3", 2'd0); rd_reg("R3", 2'd0);
        // R4: masking and registered irq
        wr_reg("R4", 2'd1, 32'h02);
        step("R4", 6'b000001, 1'b0, 1'b0, 1'b0, 2'd0, 0);
        idle("R4", 2);
        step("R4", 6'b000010, 1'b0, 1'b0, 1'b0, 2'd0, 0);
        idle("R4", 3);
        rd_reg("R4", 2'd0);
        idle("R4", 2);
        // R6: writes to status are ignored
        step("R6", 6'b100000, 1'b0, 1'b0, 1'b0, 2'd0, 0);
        wr_reg("R6", 2'd0, 32'hFFFF_FFFF);
        rd_reg("R6", 2'd0);
        wr_reg("R6", 2'd0, 32'h0000_00FF);
        rd_reg("R6", 2'd0);
        // R7: event in the read cycle survives
        step("R7", 6'b000001, 1'b0, 1'b0, 1'b0, 2'd0, 0);
        step("R7", 6'b001000, 1'b1, 1'b1, 1'b0, 2'd0, 0);
        rd_reg("R7", 2'd0); rd_reg("R7", 2'd0);
        // R8: counter run, clear and readback
        wr_reg("R8", 2'd2, 32'hDEAD_BEEF);
        rd_reg("R8", 2'd2); idle("R8", 4); rd_reg("R8", 2'd2);
        // R9: nonzero compare fires each match
        wr_reg("R9", 2'd1, 32'h80);
        wr_reg("R9", 2'd3, 32'd10);
        wr_reg("R9", 2'd2, 32'd0);
        idle("R9", 14);
        rd_reg("R9", 2'd0);
        idle("R9", 2);
        wr_reg("R9", 2'd2, 32'd0);
        idle("R9", 14);
        rd_reg("R9", 2'd0);
        // R10: zero compare never fires
        wr_reg("R10", 2'd3, 32'd0);
        wr_reg("R10", 2'd2, 32'd0);
        idle("R10", 40);
        rd_reg("R10", 2'd0);
        // R11: mask and compare readback, rdata holds
        wr_reg("R11", 2'd1, 32'hA5);
        wr_reg("R11", 2'd3, 32'h1234_5678);
        rd_reg("R11", 2'd1); idle("R11", 2); rd_reg("R11", 2'd3); idle("R11", 2);
        wr_reg("R11", 2'd3, 32'd0);
        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic [1:0]  a;
            logic [31:0] d;
            a = 2'($urandom % 4);
            d = (a == 2'd3) ? 32'($urandom % 40) : $urandom;
            step("R4", ($urandom % 4 == 0) ? 6'($urandom) : 6'h0,
                 ($urandom % 16 == 0), ($urandom % 3 == 0), ($urandom % 6 == 0), a, d);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule